// File: doc/BRIEF.md
# Keyboard and Mouse Interrupt Latch with Port 60h Read Snooping

This block sits between an old-style keyboard controller and a legacy interrupt controller. Such controllers signal a key press (keyboard line) or a button press (auxiliary/mouse line) with a short pulse instead of holding the request until it is serviced. When latching is enabled for a line, the block turns the pulse into a level that stays up until software has read the controller's data port. When latching is disabled for a line, the raw request passes straight through.

Service is detected without taking part in the bus. The block watches a conventional PCI bus passively. It recognises an I/O read of address 60h from the address phase, and it raises a one-clock strobe when that transaction's first data transfer completes. Whether this device or some other agent claims the cycle makes no difference. The strobe clears the held requests.

The block contains two state machines. The snoop machine has four states:
- `SN_IDLE`: waits for an address phase.
- `SN_HIT`: a port 60h read is in progress and no data has moved yet.
- `SN_MISS`: some other transaction is running.
- `SN_DONE`: the strobe has already fired for this transaction.

Its transitions are:
- addr-hit: `SN_IDLE` to `SN_HIT`.
- addr-miss: `SN_IDLE` to `SN_MISS`.
- first-xfer: `SN_HIT` to `SN_DONE`, which fires the strobe.
- abort: `SN_HIT` to `SN_IDLE` when the bus goes idle with no transfer.
- bus-idle: `SN_MISS` or `SN_DONE` to `SN_IDLE`.

Each interrupt line has its own two-state machine, `LN_EMPTY` and `LN_HELD`. Its transitions are:
- capture: `LN_EMPTY` to `LN_HELD` on an enabled rising edge.
- service: `LN_HELD` to `LN_EMPTY` on the strobe when no new edge arrives.
- disable: `LN_HELD` to `LN_EMPTY` when the enable bit is clear.

Top module: `kbd_irq_latch`

## Requirements
- R1: While `rst_n` is low, `rd60_pulse` is 0 and both line machines are `LN_EMPTY`. With the enable bits set and raw inputs low, both outputs are therefore 0, immediately and after reset is released.
- R2: With a line's enable bit set, a raw input sampled 1 on a clock edge after being sampled 0 on the previous edge drives that line's output to 1 right after that edge. Before that edge the output stays 0.
- R3: With the enable bit set, a captured request keeps the output at 1 after the raw input falls. It stays at 1 for any number of clocks until a strobe clears it.
- R4: With a line's enable bit clear, that line's output equals its raw input combinationally. One clock edge with the bit clear discards any held request, so setting the bit again leaves the output at 0.
- R5: An address phase is the first clock on which `pci_frame_n` is sampled 0 while the snoop machine is idle. It counts as a port 60h read only when `pci_cbe_n` is 4'b0010 and `pci_ad` is exactly 32'h0000_0060.
- R6: For a matching transaction, `rd60_pulse` is 1 for exactly one clock. That clock immediately follows the first clock edge at which `pci_irdy_n` and `pci_trdy_n` are both sampled 0. The strobe fires once per transaction, however many data phases follow.
- R7: On the clock edge at which `rd60_pulse` is 1, every enabled line in `LN_HELD` returns to `LN_EMPTY`, so its output is 0 after that edge.
- R8: A raw rising edge sampled on the same edge as an active strobe leaves that line held, so the output stays 1.
- R9: Transactions with any other command, or with any other address (including 32'h0001_0060), produce no strobe and leave held requests in place.
- R10: A matching transaction whose bus returns idle (`pci_frame_n` and `pci_irdy_n` both 1) without a data transfer produces no strobe. The snoop machine returns to `SN_IDLE` and recognises the next transaction.
- R11: The two lines are independent. Each line's enable bit and raw input affect only that line's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_kbd_raw | input | 1 | Raw keyboard interrupt request from the controller |
| irq_aux_raw | input | 1 | Raw auxiliary (mouse) interrupt request from the controller |
| latch_en_kbd | input | 1 | 1 = latch the keyboard line; 0 = pass it through |
| latch_en_aux | input | 1 | 1 = latch the auxiliary line; 0 = pass it through |
| pci_frame_n | input | 1 | Observed FRAME#, active low |
| pci_cbe_n | input | 4 | Observed command / byte enables |
| pci_ad | input | 32 | Observed address / data bus |
| pci_irdy_n | input | 1 | Observed initiator ready, active low |
| pci_trdy_n | input | 1 | Observed target ready, active low |
| irq_kbd_out | output | 1 | Keyboard request level to the interrupt controller |
| irq_aux_out | output | 1 | Auxiliary request level to the interrupt controller |
| rd60_pulse | output | 1 | One-clock strobe: a port 60h read has completed |

## Verification
A wrong state in the snoop machine shows up in one of two ways. A strobe may be missing on the clock after a port 60h read's first handshake. Or a strobe may appear after some other cycle, in which case a held output drops one clock later. Either error shows within two clocks of the data phase. A machine that is stuck would miss the next matching read, so each abort and each miss is followed by a matching read. A wrong line state shows as an output that fails to rise one clock after an enabled edge, falls without a strobe, or survives a strobe or a disable.

// File: rtl/kbl_pkg.sv
package kbl_pkg;

    // snoop machine: one transaction at a time on the observed bus
    typedef enum logic [1:0] {
        SN_IDLE = 2'd0,
        SN_HIT  = 2'd1,
        SN_MISS = 2'd2,
        SN_DONE = 2'd3
    } snoop_st_t;

    // per-line request holder
    typedef enum logic {
        LN_EMPTY = 1'b0,
        LN_HELD  = 1'b1
    } line_st_t;

    localparam int LINE_CNT = 2;
    localparam int LINE_KBD = 0;
    localparam int LINE_AUX = 1;

endpackage

// File: rtl/kbl_addr_match.sv
module kbl_addr_match #(
    parameter int              AD_W   = 32,
    parameter int              CBE_W  = 4,
    parameter logic [AD_W-1:0] PORT   = 32'h0000_0060,
    parameter logic [CBE_W-1:0] CMD   = 4'b0010
) (
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe_n,
    output logic             hit
);

    logic cmd_ok;
    logic adr_ok;

    // full-width compare: aliases of port 60h above the low bits do not match
    always_comb begin
        cmd_ok = (cbe_n == CMD);
        adr_ok = (ad == PORT);
        hit    = cmd_ok && adr_ok;
    end

endmodule

// File: rtl/kbl_snoop.sv
module kbl_snoop
    import kbl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic trdy_n,
    input  logic addr_hit,
    output logic rd_pulse
);

    snoop_st_t st;
    snoop_st_t st_nx;
    logic      bus_idle;
    logic      xfer;
    logic      fire;

    always_comb begin
        bus_idle = frame_n && irdy_n;
        xfer     = !irdy_n && !trdy_n;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        fire  = 1'b0;
        unique case (st)
            SN_IDLE: begin
                if (!frame_n) begin
                    st_nx = addr_hit ? SN_HIT : SN_MISS;   // addr-hit / addr-miss
                end
            end
            SN_HIT: begin
                if (xfer) begin
                    st_nx = SN_DONE;                       // first-xfer
                    fire  = 1'b1;
                end else if (bus_idle) begin
                    st_nx = SN_IDLE;                       // abort
                end
            end
            SN_MISS: begin
                if (bus_idle) begin
                    st_nx = SN_IDLE;                       // bus-idle
                end
            end
            SN_DONE: begin
                if (bus_idle) begin
                    st_nx = SN_IDLE;                       // bus-idle
                end
            end
            default: st_nx = SN_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= SN_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // output register: the strobe is one clock wide by construction of SN_DONE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pulse <= 1'b0;
        end else begin
            rd_pulse <= fire;
        end
    end

endmodule

// File: rtl/kbl_line.sv
module kbl_line
    import kbl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic en,
    input  logic clr,
    output logic irq_o
);

    line_st_t st;
    line_st_t st_nx;
    logic     raw_q;
    logic     rise;

    always_comb begin
        rise = raw && !raw_q;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            LN_EMPTY: begin
                if (en && rise) begin
                    st_nx = LN_HELD;                        // capture
                end
            end
            LN_HELD: begin
                if (!en) begin
                    st_nx = LN_EMPTY;                       // disable
                end else if (clr && !rise) begin
                    st_nx = LN_EMPTY;                       // service
                end
            end
            default: st_nx = LN_EMPTY;
        endcase
    end

    // state and edge-detect registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= LN_EMPTY;
            raw_q <= 1'b0;
        end else begin
            st    <= st_nx;
            raw_q <= raw;
        end
    end

    // output: held level when latching, raw line otherwise
    always_comb begin
        irq_o = en ? (st == LN_HELD) : raw;
    end

endmodule

// File: rtl/kbd_irq_latch.sv
module kbd_irq_latch
    import kbl_pkg::*;
#(
    parameter int               AD_W       = 32,
    parameter int               CBE_W      = 4,
    parameter logic [AD_W-1:0]  SNOOP_PORT = 32'h0000_0060,
    parameter logic [CBE_W-1:0] SNOOP_CMD  = 4'b0010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_kbd_raw,
    input  logic             irq_aux_raw,
    input  logic             latch_en_kbd,
    input  logic             latch_en_aux,
    input  logic             pci_frame_n,
    input  logic [CBE_W-1:0] pci_cbe_n,
    input  logic [AD_W-1:0]  pci_ad,
    input  logic             pci_irdy_n,
    input  logic             pci_trdy_n,
    output logic             irq_kbd_out,
    output logic             irq_aux_out,
    output logic             rd60_pulse
);

    logic                addr_hit;
    logic [LINE_CNT-1:0] raw_v;
    logic [LINE_CNT-1:0] en_v;
    logic [LINE_CNT-1:0] out_v;

    kbl_addr_match #(
        .AD_W  (AD_W),
        .CBE_W (CBE_W),
        .PORT  (SNOOP_PORT),
        .CMD   (SNOOP_CMD)
    ) u_match (
        .ad    (pci_ad),
        .cbe_n (pci_cbe_n),
        .hit   (addr_hit)
    );

    kbl_snoop u_snoop (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (pci_frame_n),
        .irdy_n   (pci_irdy_n),
        .trdy_n   (pci_trdy_n),
        .addr_hit (addr_hit),
        .rd_pulse (rd60_pulse)
    );

    always_comb begin
        raw_v           = '0;
        en_v            = '0;
        raw_v[LINE_KBD] = irq_kbd_raw;
        raw_v[LINE_AUX] = irq_aux_raw;
        en_v[LINE_KBD]  = latch_en_kbd;
        en_v[LINE_AUX]  = latch_en_aux;
    end

    for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
        kbl_line u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_v[i]),
            .en    (en_v[i]),
            .clr   (rd60_pulse),
            .irq_o (out_v[i])
        );
    end

    always_comb begin
        irq_kbd_out = out_v[LINE_KBD];
        irq_aux_out = out_v[LINE_AUX];
    end

endmodule

// File: rtl/kbl_chk.sv
module kbl_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_kbd_raw,
    input logic irq_aux_raw,
    input logic latch_en_kbd,
    input logic latch_en_aux,
    input logic pci_irdy_n,
    input logic pci_trdy_n,
    input logic irq_kbd_out,
    input logic irq_aux_out,
    input logic rd60_pulse
);

    logic kbd_prev;
    logic aux_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kbd_prev <= 1'b0;
            aux_prev <= 1'b0;
        end else begin
            kbd_prev <= irq_kbd_raw;
            aux_prev <= irq_aux_raw;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !rd60_pulse);

    // R2
    kbd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en_kbd && irq_kbd_raw && !kbd_prev) ##1 latch_en_kbd |-> irq_kbd_out);

    // R2
    aux_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en_aux && irq_aux_raw && !aux_prev) ##1 latch_en_aux |-> irq_aux_out);

    // R3
    kbd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en_kbd && irq_kbd_out && !rd60_pulse) ##1 latch_en_kbd |-> irq_kbd_out);

    // R3
    aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en_aux && irq_aux_out && !rd60_pulse) ##1 latch_en_aux |-> irq_aux_out);

    // R4
    kbd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en_kbd |-> (irq_kbd_out == irq_kbd_raw));

    // R4
    aux_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en_aux |-> (irq_aux_out == irq_aux_raw));

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd60_pulse |=> !rd60_pulse);

    // R6
    pulse_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd60_pulse |-> $past(!pci_irdy_n && !pci_trdy_n));

    // R7
    kbd_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en_kbd && rd60_pulse && !(irq_kbd_raw && !kbd_prev)) ##1 latch_en_kbd
        |-> !irq_kbd_out);

    // R7
    aux_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en_aux && rd60_pulse && !(irq_aux_raw && !aux_prev)) ##1 latch_en_aux
        |-> !irq_aux_out);

endmodule

bind kbd_irq_latch kbl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_kbd_raw  (irq_kbd_raw),
    .irq_aux_raw  (irq_aux_raw),
    .latch_en_kbd (latch_en_kbd),
    .latch_en_aux (latch_en_aux),
    .pci_irdy_n   (pci_irdy_n),
    .pci_trdy_n   (pci_trdy_n),
    .irq_kbd_out  (irq_kbd_out),
    .irq_aux_out  (irq_aux_out),
    .rd60_pulse   (rd60_pulse)
);

// File: tb/kbd_irq_latch_test.sv
`timescale 1ns/1ps
module kbd_irq_latch_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_kbd_raw, irq_aux_raw;
    logic        latch_en_kbd, latch_en_aux;
    logic        pci_frame_n, pci_irdy_n, pci_trdy_n;
    logic [3:0]  pci_cbe_n;
    logic [31:0] pci_ad;
    logic        irq_kbd_out, irq_aux_out, rd60_pulse;

    int checks = 0;
    int fails  = 0;
    int pulse_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    kbd_irq_latch uut (
        .clk(clk), .rst_n(rst_n),
        .irq_kbd_raw(irq_kbd_raw), .irq_aux_raw(irq_aux_raw),
        .latch_en_kbd(latch_en_kbd), .latch_en_aux(latch_en_aux),
        .pci_frame_n(pci_frame_n), .pci_cbe_n(pci_cbe_n), .pci_ad(pci_ad),
        .pci_irdy_n(pci_irdy_n), .pci_trdy_n(pci_trdy_n),
        .irq_kbd_out(irq_kbd_out), .irq_aux_out(irq_aux_out),
        .rd60_pulse(rd60_pulse)
    );

    // strobe counter, sampled away from the active edge
    always @(negedge clk) if (rst_n && rd60_pulse) pulse_cnt++;

    // vector: {cmd[3:0], addr[31:0], wait states[1:0], strobe expected}
    localparam int NV = 7;
    localparam logic [38:0] VEC [NV] = '{
        {4'b0010, 32'h0000_0060, 2'd0, 1'b1},
        {4'b0010, 32'h0000_0064, 2'd0, 1'b0},
        {4'b0011, 32'h0000_0060, 2'd0, 1'b0},
        {4'b0110, 32'h0000_0060, 2'd1, 1'b0},
        {4'b0010, 32'h0001_0060, 2'd0, 1'b0},
        {4'b0010, 32'h0000_0060, 2'd3, 1'b1},
        {4'b1010, 32'h0000_0060, 2'd0, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_lines();
        irq_kbd_raw = 1'b1; irq_aux_raw = 1'b1; tick();
        irq_kbd_raw = 1'b0; irq_aux_raw = 1'b0; tick();
    endtask

    task automatic bus_cycle(input logic [3:0] cmd, input logic [31:0] addr,
                             input int waits, input int phases);
        pci_frame_n = 1'b0; pci_cbe_n = cmd; pci_ad = addr;
        tick();
        for (int p = 0; p < phases; p++) begin
            pci_cbe_n = 4'b0000; pci_ad = 32'h5A5A_0000 + p;
            pci_irdy_n = 1'b0; pci_trdy_n = 1'b1;
            if (p == phases - 1) pci_frame_n = 1'b1;
            for (int w = 0; w < waits; w++) tick();
            pci_trdy_n = 1'b0;
            tick();
        end
        pci_irdy_n = 1'b1; pci_trdy_n = 1'b1;
        tick();
        tick();
    endtask

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            finish_up();
        end
    end

    initial begin
        rst_n = 1'b0;
        irq_kbd_raw = 1'b0; irq_aux_raw = 1'b0;
        latch_en_kbd = 1'b1; latch_en_aux = 1'b1;
        pci_frame_n = 1'b1; pci_irdy_n = 1'b1; pci_trdy_n = 1'b1;
        pci_cbe_n = 4'hF; pci_ad = '0;
        tick(); tick();
        check(!rd60_pulse && !irq_kbd_out && !irq_aux_out, "R1 reset",
              {rd60_pulse, irq_kbd_out, irq_aux_out}, 0);
        rst_n = 1'b1;
        tick();
        check(!irq_kbd_out && !irq_aux_out, "R1 after release",
              {irq_kbd_out, irq_aux_out}, 0);

        // R2: output rises right after the edge that samples the rise
        irq_kbd_raw = 1'b1; #1;
        check(irq_kbd_out == 1'b0, "R2 before edge", irq_kbd_out, 0);
        tick();
        check(irq_kbd_out == 1'b1, "R2 after edge", irq_kbd_out, 1);
        irq_kbd_raw = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        check(irq_kbd_out == 1'b1, "R3 held", irq_kbd_out, 1);
        check(irq_aux_out == 1'b0, "R11 aux untouched", irq_aux_out, 0);

        // table walk: R5 matches, R9 non-matches, R7 clearing
        for (int v = 0; v < NV; v++) begin
            hold_lines();
            pulse_cnt = 0;
            bus_cycle(VEC[v][38:35], VEC[v][34:3], int'(VEC[v][2:1]), 1);
            check(pulse_cnt == int'(VEC[v][0]), VEC[v][0] ? "R5 strobe count" : "R9 strobe count",
                  pulse_cnt, VEC[v][0]);
            check(irq_kbd_out == !VEC[v][0] && irq_aux_out == !VEC[v][0],
                  VEC[v][0] ? "R7 cleared" : "R9 kept",
                  {irq_kbd_out, irq_aux_out}, {!VEC[v][0], !VEC[v][0]});
        end

        // R6: multi-phase burst fires once
        hold_lines();
        pulse_cnt = 0;
        bus_cycle(4'b0010, 32'h60, 0, 3);
        check(pulse_cnt == 1, "R6 burst once", pulse_cnt, 1);

        // R6 exact timing and R8 coincident rise
        hold_lines();
        pci_frame_n = 1'b0; pci_cbe_n = 4'b0010; pci_ad = 32'h60; tick();
        pci_frame_n = 1'b1; pci_irdy_n = 1'b0; pci_trdy_n = 1'b0;
        check(rd60_pulse == 1'b0, "R6 not early", rd60_pulse, 0);
        tick();
        check(rd60_pulse == 1'b1, "R6 strobe clock", rd60_pulse, 1);
        irq_kbd_raw = 1'b1; pci_irdy_n = 1'b1; pci_trdy_n = 1'b1;
        tick();
        check(rd60_pulse == 1'b0, "R6 width", rd60_pulse, 0);
        check(irq_kbd_out == 1'b1, "R8 coincident rise", irq_kbd_out, 1);
        check(irq_aux_out == 1'b0, "R7 aux cleared", irq_aux_out, 0);
        irq_kbd_raw = 1'b0;
        bus_cycle(4'b0010, 32'h60, 0, 1);

        // R10: aborted match, then recovery
        hold_lines();
        pulse_cnt = 0;
        pci_frame_n = 1'b0; pci_cbe_n = 4'b0010; pci_ad = 32'h60; tick();
        pci_frame_n = 1'b1; pci_irdy_n = 1'b0; tick();
        pci_irdy_n = 1'b1; tick();
        pci_irdy_n = 1'b0; pci_trdy_n = 1'b0; tick();
        pci_irdy_n = 1'b1; pci_trdy_n = 1'b1; tick(); tick();
        check(pulse_cnt == 0, "R10 no strobe", pulse_cnt, 0);
        check(irq_kbd_out && irq_aux_out, "R10 kept", {irq_kbd_out, irq_aux_out}, 3);
        bus_cycle(4'b0010, 32'h60, 0, 1);
        check(pulse_cnt == 1, "R10 recovered", pulse_cnt, 1);

        // R4: pass-through and discard
        hold_lines();
        latch_en_kbd = 1'b0; #1;
        check(irq_kbd_out == 1'b0, "R4 follows raw low", irq_kbd_out, 0);
        irq_kbd_raw = 1'b1; #1;
        check(irq_kbd_out == 1'b1, "R4 follows raw high", irq_kbd_out, 1);
        irq_kbd_raw = 1'b0; tick();
        latch_en_kbd = 1'b1; #1;
        check(irq_kbd_out == 1'b0, "R4 discarded", irq_kbd_out, 0);
        check(irq_aux_out == 1'b1, "R11 aux still held", irq_aux_out, 1);

        // R11: aux pass-through while kbd is serviced
        hold_lines();
        latch_en_aux = 1'b0; irq_aux_raw = 1'b1;
        bus_cycle(4'b0010, 32'h60, 0, 1);
        check(irq_aux_out == 1'b1 && irq_kbd_out == 1'b0, "R11 independent",
              {irq_kbd_out, irq_aux_out}, 1);
        irq_aux_raw = 1'b0; latch_en_aux = 1'b1; tick();

        // R1: reset while held
        hold_lines();
        rst_n = 1'b0; #1;
        check(!irq_kbd_out && !irq_aux_out, "R1 reset clears",
              {irq_kbd_out, irq_aux_out}, 0);
        tick(); rst_n = 1'b1; tick();
        check(!irq_kbd_out && !irq_aux_out && !rd60_pulse, "R1 stays clear",
              {irq_kbd_out, irq_aux_out, rd60_pulse}, 0);

        finish_up();
    end

endmodule